// File: doc/BRIEF.md
# Drawing Command Queue Front End

This block sits between a host register port and a pixel engine. Software writes 32-bit command words into a 16-entry queue. Before it writes a command, it reads a free-slot count to make sure the whole command fits. The block takes words from the head of the queue and assembles complete drawing commands. Three kinds are recognised: a two-word mode command that selects the pixel size, a three-word solid rectangle fill, and a four-word rectangle copy. Each command goes to the engine as a set of unpacked fields, qualified by a valid/ready handshake.

A command leaves the queue only once every one of its words is present, so the engine never sees a partial command. A status word carries the busy bits that software polls, plus two sticky error flags. A soft-reset input empties the queue, drops any command waiting at the output, and clears the flags.

Top module: `draw_cmd_frontend`

## Requirements
- R1: `free_slots` equals 16 minus the number of words held in the queue. It changes on the clock edge that stores a word and on the edge that consumes a command. It reads 16 after reset.
- R2: A write while `free_slots` is 0 is dropped, leaving the queue contents unchanged. It sets status bit 16, which stays set until soft reset or reset.
- R3: Header 0x09410000 starts a three-word fill. The second word gives the origin and the third word gives the size. Each of them packs the vertical value in bits 31:16 and the horizontal value in bits 15:0. The block issues `cmd_kind` = 1 with x0/y0 set to the origin, w/h set to the size, and x1/y1 set to 0.
- R4: A header whose bits 31:24 equal 0x0D starts a four-word copy, whatever its low 24 bits hold. The three following words are the source point, the destination point and the size, each packed as in R3. The block issues `cmd_kind` = 2 with x0/y0 set to the source, x1/y1 set to the destination and w/h set to the size.
- R5: Header 0xF1010108 starts a two-word mode command. The block issues `cmd_kind` = 0, with `cmd_bpp2` equal to bit 15 of the second word (1 means two bytes per pixel) and all coordinate fields 0.
- R6: Any other header is removed from the queue as a one-word command and nothing is issued for it. It sets status bit 17, which is sticky like bit 16.
- R7: While the queue holds fewer words than the head command needs, no command is issued. Status bit 4 is set during that time.
- R8: Once `cmd_valid` is high, it and every command field stay unchanged until a cycle with `cmd_ready` high.
- R9: The busy bits are 0, 4, 5 and 8, which make up mask 0x131. They mean, in that order: queue not empty, partial command (R7), `engine_busy` high, and a command waiting at the output. The masked status is zero only when the queue is empty, no command is pending and the engine is idle.
- R10: A cycle with `soft_rst` high empties the queue, drops the output command and clears bits 16 and 17. A write in that same cycle is discarded.
- R11: After reset, `free_slots` is 16, `status` is 0 and `cmd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Synchronous flush of queue, output and flags |
| wr_en | input | 1 | Host command-word write strobe |
| wr_data | input | 32 | Host command word |
| free_slots | output | 5 | Number of empty queue entries |
| status | output | 32 | Busy bits 0/4/5/8, overflow bit 16, bad-header bit 17 |
| engine_busy | input | 1 | Downstream engine is executing |
| cmd_ready | input | 1 | Engine accepts the current command |
| cmd_valid | output | 1 | Assembled command available |
| cmd_kind | output | 2 | 0 mode, 1 fill, 2 copy |
| cmd_x0 | output | 16 | Fill origin x or copy source x |
| cmd_y0 | output | 16 | Fill origin y or copy source y |
| cmd_x1 | output | 16 | Copy destination x |
| cmd_y1 | output | 16 | Copy destination y |
| cmd_w | output | 16 | Rectangle width |
| cmd_h | output | 16 | Rectangle height |
| cmd_bpp2 | output | 1 | Mode command: two bytes per pixel |

## Verification
The bench sweeps many coordinate patterns through fills, copies and both pixel sizes. A design that swapped the packed halves, or read the wrong queue entry, would show up as a wrong field. It fills the queue one word at a time behind a held output and then writes once more. This catches an off-by-one in the slot count, and it catches a full write that corrupts the queue or fails to raise the overflow flag. Headers that differ from a valid one by a single low bit must be discarded, so a decoder that matches too loosely would issue a phantom command. A soft reset issued midway through a command must leave the next command aligned, which exposes a flush that leaves stale words behind.

// File: rtl/draw_fe_pkg.sv
// Shared constants and types for the drawing command front end.
// Assumes 32-bit command words with two 16-bit packed coordinates.
package draw_fe_pkg;
    localparam int WORD_W    = 32;
    localparam int COORD_W   = 16;
    localparam int MAX_WORDS = 4;

    localparam logic [WORD_W-1:0] HDR_FILL     = 32'h0941_0000;
    localparam logic [WORD_W-1:0] HDR_MODE     = 32'hF101_0108;
    localparam logic [7:0]        HDR_COPY_TOP = 8'h0D;
    localparam int                MODE_BPP_BIT = 15;

    localparam int ST_QUEUED  = 0;
    localparam int ST_PARTIAL = 4;
    localparam int ST_ENGINE  = 5;
    localparam int ST_HELD    = 8;
    localparam int ST_OVF     = 16;
    localparam int ST_BADHDR  = 17;
    localparam logic [WORD_W-1:0] BUSY_MASK = 32'h0000_0131;

    typedef enum logic [1:0] {
        KIND_MODE = 2'd0,
        KIND_FILL = 2'd1,
        KIND_COPY = 2'd2
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e          kind;
        logic [COORD_W-1:0] x0;
        logic [COORD_W-1:0] y0;
        logic [COORD_W-1:0] x1;
        logic [COORD_W-1:0] y1;
        logic [COORD_W-1:0] w;
        logic [COORD_W-1:0] h;
        logic               bpp2;
    } draw_cmd_t;
endpackage

// File: rtl/cmd_word_fifo.sv
// Circular word queue with a multi-word pop and a look-ahead window
// on the oldest PEEK entries. Assumes DEPTH is a power of two and that
// the consumer never pops more words than are held.
module cmd_word_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    parameter int PEEK  = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic                        push,
    input  logic [WIDTH-1:0]            push_data,
    input  logic [CW-1:0]               pop_cnt,
    output logic [CW-1:0]               count,
    output logic [PEEK-1:0][WIDTH-1:0]  peek,
    output logic                        dropped
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    rd_ptr;
    logic [AW-1:0]    wr_ptr;
    logic             room;
    logic             push_ok;

    // Accept a word only when a slot is free before this cycle's pop.
    always_comb begin
        room    = (count < CW'(DEPTH));
        push_ok = push && room && !flush;
        dropped = push && !room && !flush;
    end

    // Storage write port.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy update, flushed by either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + AW'(1);
            rd_ptr <= rd_ptr + AW'(pop_cnt);
            count  <= count + CW'(push_ok) - pop_cnt;
        end
    end

    // Look-ahead window on the oldest entries.
    for (genvar i = 0; i < PEEK; i++) begin : g_peek
        logic [AW-1:0] idx;
        assign idx     = rd_ptr + AW'(i);
        assign peek[i] = mem[idx];
    end
endmodule

// File: rtl/draw_cmd_assembler.sv
// Decodes the head word, waits until the whole command is queued, then
// unpacks it into an output register in one cycle and pops all its words.
// Unknown headers are popped alone and flagged. Assumes fifo_count is exact.
module draw_cmd_assembler
    import draw_fe_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              flush,
    input  logic [CW-1:0]                     fifo_count,
    input  logic [MAX_WORDS-1:0][WORD_W-1:0]  peek,
    input  logic                              cmd_ready,
    output logic [CW-1:0]                     pop_cnt,
    output draw_cmd_t                         cmd,
    output logic                              cmd_valid,
    output logic                              bad_hdr,
    output logic                              partial
);
    logic [WORD_W-1:0] head;
    logic              known;
    logic [CW-1:0]     need;
    logic              enough;
    logic              issue;
    draw_cmd_t         nxt;

    // Header decode: command length and unpacked fields.
    always_comb begin
        head     = peek[0];
        known    = 1'b1;
        need     = CW'(1);
        nxt      = '0;
        nxt.kind = KIND_MODE;
        if (head == HDR_FILL) begin
            need     = CW'(3);
            nxt.kind = KIND_FILL;
            nxt.x0   = peek[1][COORD_W-1:0];
            nxt.y0   = peek[1][WORD_W-1:COORD_W];
            nxt.w    = peek[2][COORD_W-1:0];
            nxt.h    = peek[2][WORD_W-1:COORD_W];
        end else if (head[WORD_W-1:WORD_W-8] == HDR_COPY_TOP) begin
            need     = CW'(4);
            nxt.kind = KIND_COPY;
            nxt.x0   = peek[1][COORD_W-1:0];
            nxt.y0   = peek[1][WORD_W-1:COORD_W];
            nxt.x1   = peek[2][COORD_W-1:0];
            nxt.y1   = peek[2][WORD_W-1:COORD_W];
            nxt.w    = peek[3][COORD_W-1:0];
            nxt.h    = peek[3][WORD_W-1:COORD_W];
        end else if (head == HDR_MODE) begin
            need     = CW'(2);
            nxt.kind = KIND_MODE;
            nxt.bpp2 = peek[1][MODE_BPP_BIT];
        end else begin
            known    = 1'b0;
        end
    end

    // Issue decision: complete command and an output slot (or a discard).
    always_comb begin
        enough  = (fifo_count != '0) && (fifo_count >= need);
        issue   = enough && !flush && (!known || !cmd_valid || cmd_ready);
        pop_cnt = issue ? need : '0;
        bad_hdr = issue && !known;
        partial = (fifo_count != '0) && !enough;
    end

    // Output command register with valid/ready hold.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            cmd_valid <= 1'b0;
            cmd       <= '0;
        end else if (issue && known) begin
            cmd_valid <= 1'b1;
            cmd       <= nxt;
        end else if (cmd_ready) begin
            cmd_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/draw_status_word.sv
// Builds the host status word: live busy bits plus two sticky flags.
// Sticky flags clear only on reset or flush.
module draw_status_word
    import draw_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              queued,
    input  logic              partial,
    input  logic              engine_busy,
    input  logic              held,
    input  logic              ovf_evt,
    input  logic              bad_evt,
    output logic [WORD_W-1:0] status
);
    logic ovf_q;
    logic bad_q;

    // Sticky error capture.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ovf_q <= 1'b0;
            bad_q <= 1'b0;
        end else begin
            ovf_q <= ovf_q | ovf_evt;
            bad_q <= bad_q | bad_evt;
        end
    end

    // Status word assembly.
    always_comb begin
        status             = '0;
        status[ST_QUEUED]  = queued;
        status[ST_PARTIAL] = partial;
        status[ST_ENGINE]  = engine_busy;
        status[ST_HELD]    = held;
        status[ST_OVF]     = ovf_q;
        status[ST_BADHDR]  = bad_q;
    end
endmodule

// File: rtl/draw_cmd_frontend.sv
// Top of the drawing command front end: host word queue, command
// assembler and status word. Assumes the host checks free_slots first.
module draw_cmd_frontend
    import draw_fe_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [CW-1:0]     free_slots,
    output logic [WORD_W-1:0] status,
    input  logic              engine_busy,
    input  logic              cmd_ready,
    output logic              cmd_valid,
    output logic [1:0]        cmd_kind,
    output logic [COORD_W-1:0] cmd_x0,
    output logic [COORD_W-1:0] cmd_y0,
    output logic [COORD_W-1:0] cmd_x1,
    output logic [COORD_W-1:0] cmd_y1,
    output logic [COORD_W-1:0] cmd_w,
    output logic [COORD_W-1:0] cmd_h,
    output logic              cmd_bpp2
);
    logic [CW-1:0]                    count;
    logic [CW-1:0]                    pop_cnt;
    logic [MAX_WORDS-1:0][WORD_W-1:0] peek;
    logic                             dropped;
    logic                             bad_hdr;
    logic                             partial;
    draw_cmd_t                        cmd;

    cmd_word_fifo #(
        .WIDTH (WORD_W),
        .DEPTH (DEPTH),
        .PEEK  (MAX_WORDS)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (soft_rst),
        .push      (wr_en),
        .push_data (wr_data),
        .pop_cnt   (pop_cnt),
        .count     (count),
        .peek      (peek),
        .dropped   (dropped)
    );

    draw_cmd_assembler #(
        .CW (CW)
    ) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (soft_rst),
        .fifo_count (count),
        .peek       (peek),
        .cmd_ready  (cmd_ready),
        .pop_cnt    (pop_cnt),
        .cmd        (cmd),
        .cmd_valid  (cmd_valid),
        .bad_hdr    (bad_hdr),
        .partial    (partial)
    );

    draw_status_word u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (soft_rst),
        .queued      (count != '0),
        .partial     (partial),
        .engine_busy (engine_busy),
        .held        (cmd_valid),
        .ovf_evt     (dropped),
        .bad_evt     (bad_hdr),
        .status      (status)
    );

    // Output field fan-out and free-slot arithmetic.
    always_comb begin
        free_slots = CW'(DEPTH) - count;
        cmd_kind   = cmd.kind;
        cmd_x0     = cmd.x0;
        cmd_y0     = cmd.y0;
        cmd_x1     = cmd.x1;
        cmd_y1     = cmd.y1;
        cmd_w      = cmd.w;
        cmd_h      = cmd.h;
        cmd_bpp2   = cmd.bpp2;
    end
endmodule

// File: rtl/draw_cmd_frontend_chk.sv
// Property checker for the front end, attached by bind.
module draw_cmd_frontend_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          soft_rst,
    input logic          wr_en,
    input logic [CW-1:0] free_slots,
    input logic [31:0]   status,
    input logic          cmd_ready,
    input logic          cmd_valid,
    input logic [1:0]    cmd_kind,
    input logic [15:0]   cmd_x0,
    input logic [15:0]   cmd_y0,
    input logic [15:0]   cmd_x1,
    input logic [15:0]   cmd_y1,
    input logic [15:0]   cmd_w,
    input logic [15:0]   cmd_h,
    input logic          cmd_bpp2
);
    AST_FREE_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> free_slots >= $past(free_slots)); // R1
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && free_slots == '0 && !soft_rst) |=> status[16]); // R2
    AST_BADHDR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[17] && !soft_rst) |=> status[17]); // R6
    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready && !soft_rst) |=> (cmd_valid &&
        $stable({cmd_kind, cmd_x0, cmd_y0, cmd_x1, cmd_y1, cmd_w, cmd_h, cmd_bpp2}))); // R8
    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & 32'h131) == 32'h0) |-> (free_slots == CW'(DEPTH) && !cmd_valid)); // R9
    AST_SOFT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (free_slots == CW'(DEPTH) && !cmd_valid && status[17:16] == 2'b00)); // R10
endmodule

bind draw_cmd_frontend draw_cmd_frontend_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .wr_en      (wr_en),
    .free_slots (free_slots),
    .status     (status),
    .cmd_ready  (cmd_ready),
    .cmd_valid  (cmd_valid),
    .cmd_kind   (cmd_kind),
    .cmd_x0     (cmd_x0),
    .cmd_y0     (cmd_y0),
    .cmd_x1     (cmd_x1),
    .cmd_y1     (cmd_y1),
    .cmd_w      (cmd_w),
    .cmd_h      (cmd_h),
    .cmd_bpp2   (cmd_bpp2)
);

// File: tb/tb_draw_cmd_frontend.sv
// Self-checking bench: sweeps commands, queue fill and flush cases.
module tb_draw_cmd_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [4:0]  free_slots;
    logic [31:0] status;
    logic        engine_busy = 1'b0;
    logic        cmd_ready = 1'b0;
    logic        cmd_valid;
    logic [1:0]  cmd_kind;
    logic [15:0] cmd_x0, cmd_y0, cmd_x1, cmd_y1, cmd_w, cmd_h;
    logic        cmd_bpp2;

    int  nvec = 0;
    int  nerr = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    draw_cmd_frontend dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
        .wr_data(wr_data), .free_slots(free_slots), .status(status),
        .engine_busy(engine_busy), .cmd_ready(cmd_ready), .cmd_valid(cmd_valid),
        .cmd_kind(cmd_kind), .cmd_x0(cmd_x0), .cmd_y0(cmd_y0), .cmd_x1(cmd_x1),
        .cmd_y1(cmd_y1), .cmd_w(cmd_w), .cmd_h(cmd_h), .cmd_bpp2(cmd_bpp2)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic take(input string tag, input logic [1:0] k,
                        input logic [15:0] x0, y0, x1, y1, w, h, input logic b);
        for (int i = 0; i < 8 && !cmd_valid; i++) @(negedge clk);
        chk({tag, " valid"}, 128'(cmd_valid), 128'(1));
        chk({tag, " fields"},
            128'({cmd_kind, cmd_x0, cmd_y0, cmd_x1, cmd_y1, cmd_w, cmd_h, cmd_bpp2}),
            128'({k, x0, y0, x1, y1, w, h, b}));
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nvec++; nerr++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R11 reset state
        chk("R11 free", 128'(free_slots), 128'(16));
        chk("R11 status", 128'(status), 128'(0));
        chk("R11 valid", 128'(cmd_valid), 128'(0));

        // R3 fill sweep over packed coordinates
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic [15:0] x, y, w, h;
                x = 16'(i * 4099 + j); y = 16'(j * 521 + 7);
                w = 16'(i + j * 3 + 1); h = 16'(j * 9 + i * 1000);
                wr(32'h0941_0000); wr({y, x}); wr({h, w});
                take("R3 fill", 2'd1, x, y, 16'd0, 16'd0, w, h, 1'b0);
            end
        end

        // R4 copy sweep, low header bits varied
        for (int i = 0; i < 16; i++) begin
            logic [15:0] sx, sy, dx, dy, w, h;
            sx = 16'(i * 77); sy = 16'(65535 - i * 13); dx = 16'(i * 301 + 5);
            dy = 16'(i * 3); w = 16'(i + 40); h = 16'(i * 1111);
            wr({8'h0D, 8'(i * 17), 16'(i * 4093)});
            wr({sy, sx}); wr({dy, dx}); wr({h, w});
            take("R4 copy", 2'd2, sx, sy, dx, dy, w, h, 1'b0);
        end

        // R5 mode: bit 15 selects pixel size, other bits varied
        for (int i = 0; i < 8; i++) begin
            logic [31:0] m;
            m = 32'(i * 32'h1357_2468) ^ 32'h0000_0300;
            m[15] = i[0];
            wr(32'hF101_0108); wr(m);
            take("R5 mode", 2'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, i[0]);
        end

        // R6 unknown and near-miss headers are discarded
        wr(32'h1234_5678);
        idle(2);
        chk("R6 discard valid", 128'(cmd_valid), 128'(0));
        chk("R6 discard free", 128'(free_slots), 128'(16));
        chk("R6 sticky bit17", 128'(status), 128'(32'h0002_0000));
        wr(32'h0941_0001); wr(32'hF101_0109);
        idle(2);
        chk("R6 near-miss valid", 128'(cmd_valid), 128'(0));
        chk("R6 near-miss free", 128'(free_slots), 128'(16));
        wr(32'h0941_0000); wr({16'd3, 16'd4}); wr({16'd5, 16'd6});
        take("R6 after discard fill", 2'd1, 16'd4, 16'd3, 16'd0, 16'd0, 16'd6, 16'd5, 1'b0);
        soft_rst = 1'b1; idle(1); soft_rst = 1'b0;
        chk("R10 clears bit17", 128'(status), 128'(0));

        // R7 / R9 partial command then completion
        wr(32'h0941_0000);
        chk("R1 free after one", 128'(free_slots), 128'(15));
        wr({16'd10, 16'd20});
        idle(3);
        chk("R7 no issue partial", 128'(cmd_valid), 128'(0));
        chk("R9 partial status", 128'(status), 128'(32'h11));
        wr({16'd30, 16'd40});
        chk("R1 free before issue", 128'(free_slots), 128'(13));
        idle(1);
        chk("R1 free after issue", 128'(free_slots), 128'(16));
        chk("R9 held status", 128'(status), 128'(32'h100));
        take("R7 completed fill", 2'd1, 16'd20, 16'd10, 16'd0, 16'd0, 16'd40, 16'd30, 1'b0);
        chk("R9 idle status", 128'(status), 128'(0));
        engine_busy = 1'b1; idle(1);
        chk("R9 engine busy", 128'(status), 128'(32'h20));
        engine_busy = 1'b0; idle(1);
        chk("R9 engine idle", 128'(status), 128'(0));

        // R1 / R2 / R8 fill the queue behind a held command
        wr(32'h0941_0000); wr({16'd1, 16'd2}); wr({16'd3, 16'd4});
        idle(1);
        chk("R8 held valid", 128'(cmd_valid), 128'(1));
        for (int i = 0; i < 16; i++) begin
            wr(i == 0 ? 32'h0941_0000 : (i == 1 ? {16'd7, 16'd8} :
               (i == 2 ? {16'd9, 16'd11} : 32'h0)));
            chk("R1 free sweep", 128'(free_slots), 128'(15 - i));
        end
        wr(32'h0941_0000);
        chk("R2 full free", 128'(free_slots), 128'(0));
        chk("R2 overflow status", 128'(status), 128'(32'h0001_0101));
        chk("R8 still held fields", 128'({cmd_valid, cmd_x0, cmd_y0, cmd_w, cmd_h}),
            128'({1'b1, 16'd2, 16'd1, 16'd4, 16'd3}));
        take("R8 first", 2'd1, 16'd2, 16'd1, 16'd0, 16'd0, 16'd4, 16'd3, 1'b0);
        take("R2 second", 2'd1, 16'd8, 16'd7, 16'd0, 16'd0, 16'd11, 16'd9, 1'b0);
        idle(20);
        chk("R2 drained free", 128'(free_slots), 128'(16));
        chk("R2 flags after drain", 128'(status), 128'(32'h0003_0000));

        // R10 soft reset mid-command and with a held command
        wr(32'h0941_0000); wr({16'd50, 16'd60});
        @(negedge clk);
        soft_rst = 1'b1; wr_en = 1'b1; wr_data = {16'd70, 16'd80};
        @(negedge clk);
        soft_rst = 1'b0; wr_en = 1'b0;
        chk("R10 flush free", 128'(free_slots), 128'(16));
        chk("R10 flush status", 128'(status), 128'(0));
        wr(32'hF101_0108); wr(32'h0000_8000);
        idle(1);
        soft_rst = 1'b1; idle(1); soft_rst = 1'b0;
        chk("R10 drop held", 128'(cmd_valid), 128'(0));
        wr(32'h0941_0000); wr({16'd12, 16'd13}); wr({16'd14, 16'd15});
        take("R10 realigned fill", 2'd1, 16'd13, 16'd12, 16'd0, 16'd0, 16'd15, 16'd14, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule